// File: doc/BRIEF.md
# Tag-Only Cache Timing Model

This block predicts whether a memory access by a simulated core hits or misses in a cache, and how many target cycles it takes. It returns no data. It holds only a tag and a valid bit for each way, plus recency state. The tag store is partitioned by thread ID, so every simulated core sees a private cache. The storage is sized once, for the largest geometry. At run time, configuration inputs select how much of it is used: the line size, the number of sets and the number of ways, together with the hit latency. A miss penalty input, normally driven by a downstream memory timing model, is added on a miss.

Each accepted request gets one response one cycle later. The response carries a hit flag and a latency. On a miss, a request for the line-aligned address goes out towards the next level in the same cycle. A flush command invalidates every entry for all threads. It walks one thread/set pair per clock and refuses requests while it runs. The replacement policy is a parameter. Least-recently-used is the default, and first-in-first-out is the alternative.

Top module: `cache_tm`

## Requirements
- R1: After reset, busy_o, resp_valid_o and miss_valid_o are low, and every entry is invalid, so the first access to any line misses.
- R2: A request accepted at a clock edge (req_valid_i high, busy_o low, flush_i low) produces exactly one cycle of resp_valid_o after that edge, with resp_tid_o equal to the request thread.
- R3: resp_lat_o equals cfg_hit_lat_i on a hit, and cfg_hit_lat_i plus miss_penalty_i on a miss (LAT_W+1 bits, no overflow).
- R4: miss_valid_o is high in exactly the response cycles that report a miss. miss_addr_o is the request address with its low cfg_line_bits_i bits cleared, and miss_tid_o is the request thread.
- R5: The set index is bits [cfg_line_bits_i + cfg_set_bits_i - 1 : cfg_line_bits_i] of the address (no bits when cfg_set_bits_i is 0). The tag is the address shifted right by cfg_line_bits_i + cfg_set_bits_i, so two addresses in the same line always match.
- R6: Only ways 0 to cfg_ways_i-1 take part in lookup and replacement, with a value of 0 treated as 1. Within one set and thread, at most cfg_ways_i distinct lines stay resident.
- R7: With the default policy, a miss fills the lowest-numbered invalid active way, or else evicts the least recently accessed active line. Both hits and fills count as accesses.
- R8: Each thread ID has its own tag state. A line brought in by one thread does not make an access by another thread hit.
- R9: A flush_i pulse while idle raises busy_o for exactly 2^(TID_W+SET_BITS) cycles. Afterwards, every line of every thread misses.
- R10: A request in a cycle where busy_o or flush_i is high is dropped. It gives no response, and the line it names stays absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ways_i | input | WAYS_CW | Active associativity, 1..MAX_WAYS |
| cfg_line_bits_i | input | SHIFT_W | log2 of line size in bytes |
| cfg_set_bits_i | input | SETB_W | log2 of set count, 0..SET_BITS |
| cfg_hit_lat_i | input | LAT_W | Hit latency in target cycles |
| miss_penalty_i | input | LAT_W | Extra cycles added on a miss |
| flush_i | input | 1 | Start invalidation sweep |
| req_valid_i | input | 1 | Access request strobe |
| req_tid_i | input | TID_W | Requesting thread |
| req_addr_i | input | ADDR_W | Physical byte address |
| busy_o | output | 1 | Flush sweep in progress |
| resp_valid_o | output | 1 | Response strobe |
| resp_hit_o | output | 1 | Access hit |
| resp_lat_o | output | LAT_W+1 | Modelled latency |
| resp_tid_o | output | TID_W | Thread of the response |
| miss_valid_o | output | 1 | Line fetch request to next level |
| miss_tid_o | output | TID_W | Thread of the fetch |
| miss_addr_o | output | ADDR_W | Line-aligned fetch address |

## Verification
The assertions relate latency and alignment to the configuration and penalty of the previous cycle. They therefore take the configuration and miss_penalty_i to be steady between a request and its response. They also take cfg_set_bits_i to stay within SET_BITS, and the geometry to change only across a flush. The stimulus changes these inputs only while no request is outstanding, and it flushes before every geometry change. Its reference model, a recency-ordered list per thread and set, is valid only under that discipline.

// File: rtl/cache_tm_pkg.sv
package cache_tm_pkg;
  typedef enum logic {MODE_RUN, MODE_FLUSH} mode_e;
  typedef enum logic {POL_LRU, POL_FIFO} repl_pol_e;
endpackage

// File: rtl/cache_tm_addr.sv
module cache_tm_addr #(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 4,
  parameter int SHIFT_W  = 5,
  parameter int SETB_W   = 3
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [SHIFT_W-1:0]  line_bits_i,
  input  logic [SETB_W-1:0]   set_bits_i,
  output logic [SET_BITS-1:0] set_o,
  output logic [ADDR_W-1:0]   tag_o,
  output logic [ADDR_W-1:0]   line_o
);
  logic [ADDR_W-1:0] shifted, set_mask, line_mask;

  assign shifted   = addr_i >> line_bits_i;
  assign set_mask  = ~({ADDR_W{1'b1}} << set_bits_i);
  assign line_mask = {ADDR_W{1'b1}} << line_bits_i;
  assign set_o     = SET_BITS'(shifted & set_mask);
  assign tag_o     = shifted >> set_bits_i;
  assign line_o    = addr_i & line_mask;
endmodule

// File: rtl/cache_tm_match.sv
module cache_tm_match #(
  parameter int MAX_WAYS = 4,
  parameter int ADDR_W   = 32,
  parameter int WAY_W    = 2,
  parameter int WAYS_CW  = 3
) (
  input  logic [WAYS_CW-1:0]               ways_i,
  input  logic [MAX_WAYS-1:0]              valid_i,
  input  logic [MAX_WAYS-1:0][ADDR_W-1:0]  tags_i,
  input  logic [ADDR_W-1:0]                tag_i,
  output logic [MAX_WAYS-1:0]              active_o,
  output logic                             hit_o,
  output logic [WAY_W-1:0]                 hit_way_o
);
  logic [WAYS_CW-1:0]  eff_ways;
  logic [MAX_WAYS-1:0] match;

  assign eff_ways = (ways_i == '0) ? WAYS_CW'(1) : ways_i;

  for (genvar w = 0; w < MAX_WAYS; w++) begin : g_way
    assign active_o[w] = WAYS_CW'(w) < eff_ways;
    assign match[w]    = active_o[w] && valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    hit_o     = 1'b0;
    hit_way_o = '0;
    for (int w = MAX_WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cache_tm_repl.sv
module cache_tm_repl
  import cache_tm_pkg::*;
#(
  parameter int        MAX_WAYS = 4,
  parameter int        WAY_W    = 2,
  parameter repl_pol_e POLICY   = POL_LRU
) (
  input  logic [MAX_WAYS-1:0]             active_i,
  input  logic [MAX_WAYS-1:0]             valid_i,
  input  logic [MAX_WAYS-1:0][WAY_W-1:0]  age_i,
  input  logic                            hit_i,
  input  logic [WAY_W-1:0]                hit_way_i,
  output logic [WAY_W-1:0]                victim_o,
  output logic [MAX_WAYS-1:0][WAY_W-1:0]  age_o
);
  logic             found_inv, have_max;
  logic [WAY_W-1:0] best_age, touch_way, touch_age;
  logic             do_update;

  // ages form a permutation; largest active age is the oldest active way
  always_comb begin
    found_inv = 1'b0;
    have_max  = 1'b0;
    best_age  = '0;
    victim_o  = '0;
    for (int w = 0; w < MAX_WAYS; w++) begin
      if (active_i[w] && !valid_i[w] && !found_inv) begin
        found_inv = 1'b1;
        victim_o  = WAY_W'(w);
      end
    end
    if (!found_inv) begin
      for (int w = 0; w < MAX_WAYS; w++) begin
        if (active_i[w] && (!have_max || age_i[w] > best_age)) begin
          have_max = 1'b1;
          best_age = age_i[w];
          victim_o = WAY_W'(w);
        end
      end
    end
  end

  if (POLICY == POL_LRU) begin : g_lru
    assign do_update = 1'b1;
  end else begin : g_fifo
    assign do_update = !hit_i;
  end

  assign touch_way = hit_i ? hit_way_i : victim_o;
  assign touch_age = age_i[touch_way];

  always_comb begin
    for (int w = 0; w < MAX_WAYS; w++) begin
      if (!do_update)                  age_o[w] = age_i[w];
      else if (WAY_W'(w) == touch_way) age_o[w] = '0;
      else if (age_i[w] < touch_age)   age_o[w] = age_i[w] + 1'b1;
      else                             age_o[w] = age_i[w];
    end
  end
endmodule

// File: rtl/cache_tm.sv
module cache_tm
  import cache_tm_pkg::*;
#(
  parameter int        ADDR_W   = 32,
  parameter int        TID_W    = 2,
  parameter int        SET_BITS = 4,
  parameter int        MAX_WAYS = 4,
  parameter int        LAT_W    = 8,
  parameter repl_pol_e POLICY   = POL_LRU,
  localparam int WAY_W   = (MAX_WAYS > 1) ? $clog2(MAX_WAYS) : 1,
  localparam int WAYS_CW = $clog2(MAX_WAYS + 1),
  localparam int SHIFT_W = $clog2(ADDR_W),
  localparam int SETB_W  = $clog2(SET_BITS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WAYS_CW-1:0] cfg_ways_i,
  input  logic [SHIFT_W-1:0] cfg_line_bits_i,
  input  logic [SETB_W-1:0]  cfg_set_bits_i,
  input  logic [LAT_W-1:0]   cfg_hit_lat_i,
  input  logic [LAT_W-1:0]   miss_penalty_i,
  input  logic               flush_i,
  input  logic               req_valid_i,
  input  logic [TID_W-1:0]   req_tid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  output logic               busy_o,
  output logic               resp_valid_o,
  output logic               resp_hit_o,
  output logic [LAT_W:0]     resp_lat_o,
  output logic [TID_W-1:0]   resp_tid_o,
  output logic               miss_valid_o,
  output logic [TID_W-1:0]   miss_tid_o,
  output logic [ADDR_W-1:0]  miss_addr_o
);
  localparam int IDX_W   = TID_W + SET_BITS;
  localparam int ENTRIES = 1 << IDX_W;

  typedef logic [MAX_WAYS-1:0][WAY_W-1:0] ages_t;

  function automatic ages_t ramp_ages();
    ages_t r;
    for (int w = 0; w < MAX_WAYS; w++) r[w] = WAY_W'(w);
    return r;
  endfunction

  mode_e                          mode_q;
  logic [IDX_W-1:0]               flush_ptr_q;
  logic [MAX_WAYS-1:0]            valid_q [ENTRIES];
  logic [MAX_WAYS-1:0][ADDR_W-1:0] tag_q  [ENTRIES];
  ages_t                          age_q   [ENTRIES];

  logic [SET_BITS-1:0] set_idx;
  logic [ADDR_W-1:0]   req_tag, line_addr;
  logic [IDX_W-1:0]    idx;
  logic                accept, hit;
  logic [WAY_W-1:0]    hit_way, victim;
  logic [MAX_WAYS-1:0] active;
  ages_t               new_ages;

  assign idx    = {req_tid_i, set_idx};
  assign accept = req_valid_i && (mode_q == MODE_RUN) && !flush_i;
  assign busy_o = (mode_q == MODE_FLUSH);

  cache_tm_addr #(
    .ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .SHIFT_W(SHIFT_W), .SETB_W(SETB_W)
  ) u_addr (
    .addr_i(req_addr_i), .line_bits_i(cfg_line_bits_i), .set_bits_i(cfg_set_bits_i),
    .set_o(set_idx), .tag_o(req_tag), .line_o(line_addr)
  );

  cache_tm_match #(
    .MAX_WAYS(MAX_WAYS), .ADDR_W(ADDR_W), .WAY_W(WAY_W), .WAYS_CW(WAYS_CW)
  ) u_match (
    .ways_i(cfg_ways_i), .valid_i(valid_q[idx]), .tags_i(tag_q[idx]), .tag_i(req_tag),
    .active_o(active), .hit_o(hit), .hit_way_o(hit_way)
  );

  cache_tm_repl #(
    .MAX_WAYS(MAX_WAYS), .WAY_W(WAY_W), .POLICY(POLICY)
  ) u_repl (
    .active_i(active), .valid_i(valid_q[idx]), .age_i(age_q[idx]),
    .hit_i(hit), .hit_way_i(hit_way), .victim_o(victim), .age_o(new_ages)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q       <= MODE_RUN;
      flush_ptr_q  <= '0;
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_lat_o   <= '0;
      resp_tid_o   <= '0;
      miss_valid_o <= 1'b0;
      miss_tid_o   <= '0;
      miss_addr_o  <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        valid_q[e] <= '0;
        age_q[e]   <= ramp_ages();
      end
    end else begin
      resp_valid_o <= accept;
      miss_valid_o <= accept && !hit;
      if (accept) begin
        resp_hit_o  <= hit;
        resp_lat_o  <= {1'b0, cfg_hit_lat_i} + (hit ? '0 : {1'b0, miss_penalty_i});
        resp_tid_o  <= req_tid_i;
        miss_tid_o  <= req_tid_i;
        miss_addr_o <= line_addr;
        age_q[idx]  <= new_ages;
        if (!hit) valid_q[idx][victim] <= 1'b1;
      end
      case (mode_q)
        MODE_RUN: if (flush_i) begin
          mode_q      <= MODE_FLUSH;
          flush_ptr_q <= '0;
        end
        MODE_FLUSH: begin
          valid_q[flush_ptr_q] <= '0;
          age_q[flush_ptr_q]   <= ramp_ages();
          flush_ptr_q          <= flush_ptr_q + 1'b1;
          if (flush_ptr_q == IDX_W'(ENTRIES - 1)) mode_q <= MODE_RUN;
        end
        default: mode_q <= MODE_RUN;
      endcase
    end
  end

  // tags need no reset: valid bits gate them
  always_ff @(posedge clk_i) begin
    if (accept && !hit) tag_q[idx][victim] <= req_tag;
  end
endmodule

// File: rtl/cache_tm_chk.sv
module cache_tm_chk #(
  parameter int ADDR_W   = 32,
  parameter int TID_W    = 2,
  parameter int SET_BITS = 4,
  parameter int LAT_W    = 8,
  parameter int SHIFT_W  = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               flush_i,
  input logic               req_valid_i,
  input logic               busy_o,
  input logic               resp_valid_o,
  input logic               resp_hit_o,
  input logic [LAT_W:0]     resp_lat_o,
  input logic [LAT_W-1:0]   cfg_hit_lat_i,
  input logic [LAT_W-1:0]   miss_penalty_i,
  input logic [SHIFT_W-1:0] cfg_line_bits_i,
  input logic               miss_valid_o,
  input logic [ADDR_W-1:0]  miss_addr_o
);
  localparam int ENTRIES = 1 << (TID_W + SET_BITS);
  localparam int CNT_W   = TID_W + SET_BITS + 1;

  logic [CNT_W-1:0] busy_cnt_q;
  logic             take;

  assign take = req_valid_i && !busy_o && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt_q <= '0;
    else if (busy_o) busy_cnt_q <= busy_cnt_q + 1'b1;
    else             busy_cnt_q <= '0;
  end

  assert_resp_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> resp_valid_o);

  assert_no_spurious_resp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> !resp_valid_o);

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> resp_lat_o == ({1'b0, $past(cfg_hit_lat_i)} +
      (resp_hit_o ? {(LAT_W+1){1'b0}} : {1'b0, $past(miss_penalty_i)})));

  assert_miss_only_on_miss_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_o |-> (resp_valid_o && !resp_hit_o));

  assert_miss_reported_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_hit_o) |-> miss_valid_o);

  assert_miss_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_o |-> ((miss_addr_o & ~({ADDR_W{1'b1}} << $past(cfg_line_bits_i))) == '0));

  assert_busy_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(flush_i));

  assert_busy_length_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_cnt_q == CNT_W'(ENTRIES));
endmodule

bind cache_tm cache_tm_chk #(
  .ADDR_W(ADDR_W), .TID_W(TID_W), .SET_BITS(SET_BITS), .LAT_W(LAT_W), .SHIFT_W(SHIFT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .req_valid_i(req_valid_i),
  .busy_o(busy_o), .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o),
  .resp_lat_o(resp_lat_o), .cfg_hit_lat_i(cfg_hit_lat_i), .miss_penalty_i(miss_penalty_i),
  .cfg_line_bits_i(cfg_line_bits_i), .miss_valid_o(miss_valid_o), .miss_addr_o(miss_addr_o)
);

// File: tb/cache_tm_test.sv
module cache_tm_test;
  localparam int NKEYS = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  cfg_ways_i = 3'd2;
  logic [4:0]  cfg_line_bits_i = 5'd4;
  logic [2:0]  cfg_set_bits_i = 3'd2;
  logic [7:0]  cfg_hit_lat_i = 8'd3;
  logic [7:0]  miss_penalty_i = 8'd20;
  logic        flush_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_tid_i = '0;
  logic [31:0] req_addr_i = '0;
  logic        busy_o, resp_valid_o, resp_hit_o, miss_valid_o;
  logic [8:0]  resp_lat_o;
  logic [1:0]  resp_tid_o, miss_tid_o;
  logic [31:0] miss_addr_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] mq [NKEYS][$];

  always #2.5 clk_i = ~clk_i;

  cache_tm uut (.*);

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic bit model_access(input int tid, input logic [31:0] addr);
    int unsigned lb = cfg_line_bits_i;
    int unsigned sb = cfg_set_bits_i;
    int unsigned ways = (cfg_ways_i == 0) ? 1 : cfg_ways_i;
    int unsigned sidx = (addr >> lb) & ((32'd1 << sb) - 1);
    logic [31:0] tg = addr >> (lb + sb);
    int key = tid * 16 + int'(sidx);
    int pos = -1;
    for (int i = 0; i < mq[key].size(); i++) if (mq[key][i] == tg && pos < 0) pos = i;
    if (pos >= 0) mq[key].delete(pos);
    mq[key].push_front(tg);
    if (mq[key].size() > ways) void'(mq[key].pop_back());
    return pos >= 0;
  endfunction

  task automatic model_flush();
    for (int k = 0; k < NKEYS; k++) mq[k].delete();
  endtask

  // call at a negedge; returns at the negedge where the response is visible
  task automatic access(input int tid, input logic [31:0] addr, input string rq);
    bit eh;
    logic [31:0] line;
    logic [8:0] elat;
    eh = model_access(tid, addr);
    line = addr & ~((32'd1 << cfg_line_bits_i) - 1);
    elat = eh ? {1'b0, cfg_hit_lat_i} : {1'b0, cfg_hit_lat_i} + {1'b0, miss_penalty_i};
    req_valid_i = 1'b1;
    req_tid_i = 2'(tid);
    req_addr_i = addr;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(resp_valid_o == 1'b1, "R2 resp_valid", resp_valid_o, 1);
    chk(resp_tid_o == 2'(tid), "R2 resp_tid", resp_tid_o, tid);
    chk(resp_hit_o == eh, rq, resp_hit_o, eh);
    chk(resp_lat_o == elat, "R3 latency", resp_lat_o, elat);
    chk(miss_valid_o == !eh, "R4 miss_valid", miss_valid_o, !eh);
    if (!eh) begin
      chk(miss_addr_o == line, "R4 miss_addr", miss_addr_o, line);
      chk(miss_tid_o == 2'(tid), "R4 miss_tid", miss_tid_o, tid);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk(resp_valid_o == 1'b0 && miss_valid_o == 1'b0, "R2 idle", resp_valid_o, 0);
    end
  endtask

  // flush with a request in the flush cycle and one more during busy
  task automatic do_flush(input logic [31:0] probe_addr);
    int n = 0;
    flush_i = 1'b1;
    req_valid_i = 1'b1;
    req_tid_i = '0;
    req_addr_i = probe_addr;
    @(posedge clk_i);
    @(negedge clk_i);
    flush_i = 1'b0;
    req_valid_i = 1'b0;
    model_flush();
    chk(resp_valid_o == 1'b0, "R10 request with flush", resp_valid_o, 0);
    while (busy_o && n < 1000) begin
      n++;
      req_valid_i = (n == 3);
      if (n == 4) chk(resp_valid_o == 1'b0, "R10 request while busy", resp_valid_o, 0);
      @(negedge clk_i);
    end
    req_valid_i = 1'b0;
    chk(n == 64, "R9 busy length", n, 64);
  endtask

  initial begin
    logic [31:0] lcg;
    lcg = 32'h1234_5678;
    #12;
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
    chk(resp_valid_o == 1'b0, "R1 resp after reset", resp_valid_o, 0);
    chk(miss_valid_o == 1'b0, "R1 miss after reset", miss_valid_o, 0);
    rst_ni = 1'b1;
    idle(2);

    // lines 16 B, 4 sets, 2 ways
    access(0, 32'h0000_0100, "R1 first access misses");
    access(0, 32'h0000_010C, "R5 same line hits");
    access(0, 32'h0000_0110, "R5 next line other set");
    access(1, 32'h0000_0100, "R8 other thread misses");
    access(0, 32'h0000_0100, "R8 own line still hits");
    idle(1);
    // set 0 conflicts: 0x000, 0x040, 0x080
    access(2, 32'h0000_0000, "R7 fill");
    access(2, 32'h0000_0040, "R7 fill second way");
    access(2, 32'h0000_0000, "R7 hit refreshes");
    access(2, 32'h0000_0080, "R7 evicts LRU");
    access(2, 32'h0000_0000, "R7 MRU kept");
    access(2, 32'h0000_0040, "R7 evicted line misses");
    miss_penalty_i = 8'd200;
    cfg_hit_lat_i = 8'd255;
    access(2, 32'h0000_0090, "R3 max latency");
    cfg_hit_lat_i = 8'd3;
    miss_penalty_i = 8'd20;

    do_flush(32'h0000_0200);
    access(0, 32'h0000_0100, "R9 miss after flush");
    access(0, 32'h0000_0200, "R10 dropped request not filled");

    // one way, one set, 16 B lines
    cfg_ways_i = 3'd1; cfg_set_bits_i = 3'd0;
    do_flush(32'h0000_0000);
    access(3, 32'h0000_0000, "R6 fill single way");
    access(3, 32'h0000_0010, "R6 replace single way");
    access(3, 32'h0000_0000, "R6 masked ways unused");

    // three ways, one set, 64 B lines
    cfg_ways_i = 3'd3; cfg_line_bits_i = 5'd6;
    do_flush(32'h0000_0000);
    for (int i = 0; i < 4; i++) access(1, 32'(i * 64), "R6 three way fill");
    access(1, 32'h0000_0000, "R6 fourth line evicted first");
    access(1, 32'h0000_00BC, "R6 third line resident");

    // mixed traffic, four ways, 16 B lines, 2 sets
    cfg_ways_i = 3'd4; cfg_line_bits_i = 5'd4; cfg_set_bits_i = 3'd1;
    do_flush(32'h0000_0000);
    for (int i = 0; i < 400; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      access(int'(lcg[25:24]), {22'd0, lcg[13:10], 6'd0} | 32'(lcg[3:0]), "R7 mixed LRU");
      if (lcg[30:28] == 3'd0) idle(1);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule